// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps every in-flight micro-op in program order inside a circular window of entries. The front end claims one entry per cycle at the tail and receives its index, which also serves as the physical register name for that micro-op's result. Execution units write a result back into an entry by its index, together with a flag that marks a mispredicted branch or a fault. A read port lets the operand stage look up any entry by index and learn whether the value is already there.

Each cycle the block examines the oldest entries and retires a run of executed ones, up to a fixed number per cycle. For each retired entry it presents the architectural destination register and the value on a lane of the committed-register write port, then frees the entry. When the run reaches a flagged entry, that entry is retired without a register write, every younger entry is discarded, and a flush pulse is raised for the front end.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `free_cnt` equals DEPTH (40), `alloc_ready` is 1, `alloc_idx` is 0, `ret_valid` is 0, `flush` is 0 and `src_ready` is 0 for every index.
- R2: An accepted allocation is given the entry shown on `alloc_idx` in the same cycle; consecutive allocations receive consecutive indices that wrap from DEPTH-1 back to 0, and each lowers `free_cnt` by one.
- R3: When all DEPTH entries are held, `alloc_ready` is 0 and `free_cnt` is 0, and a request made then is not accepted and claims no entry.
- R4: The cycle after a completion to an allocated entry, the read port at that index gives `src_ready` = 1 and the written value on `src_data`; an allocated entry that has not completed gives `src_ready` = 0, and a completion to an index that holds no entry is ignored.
- R5: Entries retire strictly in allocation order: an executed entry never retires while an older entry is still waiting for its result.
- R6: At most RET_W (3) entries retire per cycle, and the run stops at the first entry, counted from the oldest, that has not executed.
- R7: Retire lane g carries the (g+1)-th oldest entry: `ret_valid[g]`, `ret_arch[g*ARCH_W +: ARCH_W]` and `ret_data[g*DATA_W +: DATA_W]` give its write enable, destination register and value, so `ret_valid` is always a run of ones from bit 0.
- R8: A flagged entry reached by the retire run is retired with no register write, `flush` is 1 in that cycle, and on the next cycle the buffer is empty and `alloc_idx` names the entry that followed the flagged one.
- R9: An allocation request made in a flush cycle is discarded.
- R10: Entries that retire are returned to the free pool at the next clock edge, raising `free_cnt` by the number retired.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Request to claim the tail entry |
| alloc_arch | input | ARCH_W | Architectural destination of the new micro-op |
| alloc_ready | output | 1 | Buffer has a free entry |
| alloc_idx | output | IDX_W | Index the next allocation receives |
| free_cnt | output | CNT_W | Number of unused entries |
| cpl_valid | input | 1 | Result write-back strobe |
| cpl_idx | input | IDX_W | Entry receiving the result |
| cpl_data | input | DATA_W | Result value |
| cpl_flag | input | 1 | Entry is a mispredicted branch or a fault |
| src_idx | input | IDX_W | Entry looked up for an operand |
| src_ready | output | 1 | Looked-up entry holds its result |
| src_data | output | DATA_W | Result of the looked-up entry |
| ret_valid | output | RET_W | Per-lane committed-register write enable |
| ret_arch | output | RET_W*ARCH_W | Per-lane destination register |
| ret_data | output | RET_W*DATA_W | Per-lane committed value |
| flush | output | 1 | Younger entries discarded this cycle |

## Verification
`alloc_idx`, `alloc_ready` and `free_cnt` follow the registered pointers, so an allocation's index is due in the cycle the request is held, and the new free count one edge later. A completion is captured at a rising edge and is due on the read port, the retire lanes and `flush` straight after that edge; a retired entry shows on its lane for exactly that cycle and is freed at the next edge. The bench drives and checks 1 ns after each rising edge and lets a scoreboard monitor, fed in program order by the allocation task, pop and compare retire lanes at each falling edge, so every result is observed in the single cycle it is due.

// File: rtl/rob_pkg.sv
package rob_pkg;

    // Default sizing of the reorder window.
    localparam int ROB_DEPTH  = 40;
    localparam int ROB_RET_W  = 3;
    localparam int ROB_DATA_W = 32;
    localparam int ROB_ARCH_W = 3;

    // Per-entry status bits kept beside the payload.
    typedef struct packed {
        logic busy;     // entry holds a live micro-op
        logic done;     // result has been written
        logic redirect; // mispredict or fault marker
    } ent_stat_t;

endpackage

// File: rtl/rob_entry_array.sv
module rob_entry_array
    import rob_pkg::*;
#(
    parameter int DEPTH  = ROB_DEPTH,
    parameter int DATA_W = ROB_DATA_W,
    parameter int ARCH_W = ROB_ARCH_W,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_alloc,
    input  logic [IDX_W-1:0]              wr_alloc_idx,
    input  logic [ARCH_W-1:0]             wr_alloc_arch,
    input  logic                          wr_cpl,
    input  logic [IDX_W-1:0]              wr_cpl_idx,
    input  logic [DATA_W-1:0]             wr_cpl_data,
    input  logic                          wr_cpl_flag,
    input  logic [DEPTH-1:0]              clr_mask,
    output logic [DEPTH-1:0]              busy_vec,
    output logic [DEPTH-1:0]              done_vec,
    output logic [DEPTH-1:0]              redir_vec,
    output logic [DEPTH-1:0][DATA_W-1:0]  data_arr,
    output logic [DEPTH-1:0][ARCH_W-1:0]  arch_arr
);

    typedef struct packed {
        logic [DEPTH-1:0]             busy;
        logic [DEPTH-1:0]             done;
        logic [DEPTH-1:0]             redir;
        logic [DEPTH-1:0][DATA_W-1:0] data;
        logic [DEPTH-1:0][ARCH_W-1:0] arch;
    } arr_t;

    arr_t arr_d, arr_q;

    always_comb begin
        arr_d = arr_q;
        // result write-back, only into a live entry
        if (wr_cpl && (int'(wr_cpl_idx) < DEPTH) && arr_q.busy[wr_cpl_idx]) begin
            arr_d.done[wr_cpl_idx]  = 1'b1;
            arr_d.redir[wr_cpl_idx] = wr_cpl_flag;
            arr_d.data[wr_cpl_idx]  = wr_cpl_data;
        end
        // retire or flush releases entries
        for (int i = 0; i < DEPTH; i++) begin
            if (clr_mask[i]) begin
                arr_d.busy[i]  = 1'b0;
                arr_d.done[i]  = 1'b0;
                arr_d.redir[i] = 1'b0;
            end
        end
        // a fresh entry at the tail
        if (wr_alloc && (int'(wr_alloc_idx) < DEPTH)) begin
            arr_d.busy[wr_alloc_idx]  = 1'b1;
            arr_d.done[wr_alloc_idx]  = 1'b0;
            arr_d.redir[wr_alloc_idx] = 1'b0;
            arr_d.arch[wr_alloc_idx]  = wr_alloc_arch;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_q <= '0;
        end else begin
            arr_q <= arr_d;
        end
    end

    assign busy_vec  = arr_q.busy;
    assign done_vec  = arr_q.done;
    assign redir_vec = arr_q.redir;
    assign data_arr  = arr_q.data;
    assign arch_arr  = arr_q.arch;

    // R4: a write-back aimed at an empty slot leaves it without a result
    assert_stray_cpl_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cpl && (int'(wr_cpl_idx) < DEPTH) && !busy_vec[wr_cpl_idx])
        |=> !done_vec[$past(wr_cpl_idx)]);

    // R4: a result only ever sits in a live entry
    assert_done_in_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_vec & ~busy_vec) == '0);

endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel
    import rob_pkg::*;
#(
    parameter int DEPTH = ROB_DEPTH,
    parameter int RET_W = ROB_RET_W,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int RC_W  = $clog2(RET_W + 1)
) (
    input  logic [IDX_W-1:0]            head,
    input  logic [DEPTH-1:0]            busy_vec,
    input  logic [DEPTH-1:0]            done_vec,
    input  logic [DEPTH-1:0]            redir_vec,
    output logic [RET_W-1:0][IDX_W-1:0] lane_idx,
    output logic [RET_W-1:0]            lane_take,
    output logic [RET_W-1:0]            lane_write,
    output logic [RC_W-1:0]             take_cnt,
    output logic                        redirect
);

    // Index of each retire lane, counted from the oldest entry.
    for (genvar g = 0; g < RET_W; g++) begin : g_lane
        logic [IDX_W:0] sum;
        assign sum = {1'b0, head} + (IDX_W+1)'(g);
        assign lane_idx[g] = (sum >= (IDX_W+1)'(DEPTH)) ?
                             IDX_W'(sum - (IDX_W+1)'(DEPTH)) : sum[IDX_W-1:0];
    end

    always_comb begin
        logic run;
        run        = 1'b1;
        take_cnt   = '0;
        redirect   = 1'b0;
        lane_take  = '0;
        lane_write = '0;
        for (int g = 0; g < RET_W; g++) begin
            if (run && busy_vec[lane_idx[g]] && done_vec[lane_idx[g]]) begin
                lane_take[g]  = 1'b1;
                lane_write[g] = !redir_vec[lane_idx[g]];
                take_cnt      = take_cnt + RC_W'(1);
                if (redir_vec[lane_idx[g]]) begin
                    redirect = 1'b1;
                    run      = 1'b0;
                end
            end else begin
                run = 1'b0;
            end
        end
    end

endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH  = ROB_DEPTH,
    parameter int RET_W  = ROB_RET_W,
    parameter int DATA_W = ROB_DATA_W,
    parameter int ARCH_W = ROB_ARCH_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        alloc_valid,
    input  logic [ARCH_W-1:0]           alloc_arch,
    output logic                        alloc_ready,
    output logic [$clog2(DEPTH)-1:0]    alloc_idx,
    output logic [$clog2(DEPTH+1)-1:0]  free_cnt,
    input  logic                        cpl_valid,
    input  logic [$clog2(DEPTH)-1:0]    cpl_idx,
    input  logic [DATA_W-1:0]           cpl_data,
    input  logic                        cpl_flag,
    input  logic [$clog2(DEPTH)-1:0]    src_idx,
    output logic                        src_ready,
    output logic [DATA_W-1:0]           src_data,
    output logic [RET_W-1:0]            ret_valid,
    output logic [RET_W*ARCH_W-1:0]     ret_arch,
    output logic [RET_W*DATA_W-1:0]     ret_data,
    output logic                        flush
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int RC_W  = $clog2(RET_W + 1);

    typedef struct packed {
        logic [IDX_W-1:0] head;
        logic [IDX_W-1:0] tail;
        logic [CNT_W-1:0] used;
    } ptr_t;

    ptr_t st_d, st_q;

    logic [DEPTH-1:0]             busy_vec, done_vec, redir_vec;
    logic [DEPTH-1:0][DATA_W-1:0] data_arr;
    logic [DEPTH-1:0][ARCH_W-1:0] arch_arr;
    logic [RET_W-1:0][IDX_W-1:0]  lane_idx;
    logic [RET_W-1:0]             lane_take, lane_write;
    logic [RC_W-1:0]              take_cnt;
    logic                         redirect;
    logic                         full, alloc_fire;
    logic [DEPTH-1:0]             clr_mask;
    logic [IDX_W-1:0]             head_next;

    function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] a,
                                                  input logic [IDX_W-1:0] b);
        logic [IDX_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= (IDX_W+1)'(DEPTH)) s = s - (IDX_W+1)'(DEPTH);
        return s[IDX_W-1:0];
    endfunction

    rob_entry_array #(
        .DEPTH (DEPTH),
        .DATA_W(DATA_W),
        .ARCH_W(ARCH_W)
    ) u_entries (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_alloc     (alloc_fire),
        .wr_alloc_idx (st_q.tail),
        .wr_alloc_arch(alloc_arch),
        .wr_cpl       (cpl_valid),
        .wr_cpl_idx   (cpl_idx),
        .wr_cpl_data  (cpl_data),
        .wr_cpl_flag  (cpl_flag),
        .clr_mask     (clr_mask),
        .busy_vec     (busy_vec),
        .done_vec     (done_vec),
        .redir_vec    (redir_vec),
        .data_arr     (data_arr),
        .arch_arr     (arch_arr)
    );

    rob_retire_sel #(
        .DEPTH(DEPTH),
        .RET_W(RET_W)
    ) u_retire (
        .head      (st_q.head),
        .busy_vec  (busy_vec),
        .done_vec  (done_vec),
        .redir_vec (redir_vec),
        .lane_idx  (lane_idx),
        .lane_take (lane_take),
        .lane_write(lane_write),
        .take_cnt  (take_cnt),
        .redirect  (redirect)
    );

    assign full       = (st_q.used == CNT_W'(DEPTH));
    assign alloc_fire = alloc_valid && !full && !redirect;

    always_comb begin
        st_d      = st_q;
        clr_mask  = '0;
        head_next = wrap_add(st_q.head, IDX_W'(take_cnt));
        st_d.head = head_next;
        for (int g = 0; g < RET_W; g++) begin
            if (lane_take[g]) clr_mask[lane_idx[g]] = 1'b1;
        end
        if (redirect) begin
            clr_mask  = '1;
            st_d.tail = head_next;
            st_d.used = '0;
        end else begin
            if (alloc_fire) st_d.tail = wrap_add(st_q.tail, IDX_W'(1));
            st_d.used = st_q.used - CNT_W'(take_cnt) + CNT_W'(alloc_fire);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alloc_ready = !full;
    assign alloc_idx   = st_q.tail;
    assign free_cnt    = CNT_W'(DEPTH) - st_q.used;
    assign flush       = redirect;
    assign ret_valid   = lane_write;

    for (genvar g = 0; g < RET_W; g++) begin : g_port
        assign ret_arch[g*ARCH_W +: ARCH_W] = arch_arr[lane_idx[g]];
        assign ret_data[g*DATA_W +: DATA_W] = data_arr[lane_idx[g]];
    end

    assign src_ready = (int'(src_idx) < DEPTH) && busy_vec[src_idx] && done_vec[src_idx];
    assign src_data  = (int'(src_idx) < DEPTH) ? data_arr[src_idx] : '0;

    // R3: occupancy never passes the window size
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.used <= CNT_W'(DEPTH));

    // R3: with no free entry the request side is closed
    assert_full_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cnt == '0) |-> !alloc_ready);

    // R5: the oldest lane only retires an entry holding its result
    assert_oldest_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lane_take[0] |-> done_vec[st_q.head]);

    // R8, R9: a flush leaves an empty window behind, any request dropped
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (free_cnt == CNT_W'(DEPTH)));

    // R4: an operand marked ready comes from a live entry
    assert_src_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> busy_vec[src_idx]);

    // R6: retire lanes form an unbroken run from the oldest
    for (genvar g = 1; g < RET_W; g++) begin : g_chk
        assert_lanes_in_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
            lane_take[g] |-> lane_take[g-1]);
    end

endmodule

// File: tb/rob_core_tb.sv
module rob_core_tb;

    localparam int DEPTH  = 40;
    localparam int RET_W  = 3;
    localparam int DATA_W = 32;
    localparam int ARCH_W = 3;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic                       alloc_valid = 1'b0;
    logic [ARCH_W-1:0]          alloc_arch = '0;
    logic                       alloc_ready;
    logic [IDX_W-1:0]           alloc_idx;
    logic [CNT_W-1:0]           free_cnt;
    logic                       cpl_valid = 1'b0;
    logic [IDX_W-1:0]           cpl_idx = '0;
    logic [DATA_W-1:0]          cpl_data = '0;
    logic                       cpl_flag = 1'b0;
    logic [IDX_W-1:0]           src_idx = '0;
    logic                       src_ready;
    logic [DATA_W-1:0]          src_data;
    logic [RET_W-1:0]           ret_valid;
    logic [RET_W*ARCH_W-1:0]    ret_arch;
    logic [RET_W*DATA_W-1:0]    ret_data;
    logic                       flush;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    logic [DATA_W-1:0]          val_tbl [DEPTH];
    logic [ARCH_W+DATA_W-1:0]   exp_q [$];

    always #4 clk = ~clk;

    rob_core #(
        .DEPTH(DEPTH), .RET_W(RET_W), .DATA_W(DATA_W), .ARCH_W(ARCH_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_arch(alloc_arch),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx), .free_cnt(free_cnt),
        .cpl_valid(cpl_valid), .cpl_idx(cpl_idx), .cpl_data(cpl_data), .cpl_flag(cpl_flag),
        .src_idx(src_idx), .src_ready(src_ready), .src_data(src_data),
        .ret_valid(ret_valid), .ret_arch(ret_arch), .ret_data(ret_data),
        .flush(flush)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("[TB] FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Driver: claims one entry, records the expected commit when it should retire.
    task automatic alloc_one(input int exp_idx, input logic [ARCH_W-1:0] arch,
                             input logic [DATA_W-1:0] val, input bit will_commit);
        check(alloc_ready == 1'b1, "R2 ready", alloc_ready, 1);
        check(alloc_idx == IDX_W'(exp_idx), "R2 index", alloc_idx, exp_idx);
        val_tbl[exp_idx] = val;
        if (will_commit) exp_q.push_back({arch, val});
        alloc_valid = 1'b1;
        alloc_arch  = arch;
        step();
        alloc_valid = 1'b0;
    endtask

    task automatic complete(input int idx, input bit flag);
        cpl_valid = 1'b1;
        cpl_idx   = IDX_W'(idx);
        cpl_data  = val_tbl[idx];
        cpl_flag  = flag;
        step();
        cpl_valid = 1'b0;
        cpl_flag  = 1'b0;
    endtask

    // Monitor: pops the scoreboard for each committed lane (R5, R7).
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int g = 0; g < RET_W; g++) begin
                if (ret_valid[g]) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R5 unexpected commit", ret_data[g*DATA_W +: DATA_W], 0);
                    end else begin
                        logic [ARCH_W+DATA_W-1:0] want;
                        logic [ARCH_W+DATA_W-1:0] got;
                        want = exp_q.pop_front();
                        got  = {ret_arch[g*ARCH_W +: ARCH_W], ret_data[g*DATA_W +: DATA_W]};
                        check(got == want, "R7 lane content/order", got, want);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();

        // R1: empty after reset
        check(free_cnt == CNT_W'(DEPTH), "R1 free", free_cnt, DEPTH);
        check(alloc_ready == 1'b1, "R1 ready", alloc_ready, 1);
        check(alloc_idx == '0, "R1 tail", alloc_idx, 0);
        check(ret_valid == '0, "R1 retire", ret_valid, 0);
        check(flush == 1'b0, "R1 flush", flush, 0);
        check(src_ready == 1'b0, "R1 src", src_ready, 0);

        // R2: five allocations 0..4
        for (int i = 0; i < 5; i++) alloc_one(i, ARCH_W'(i + 1), 32'hA000 + i, 1'b1);
        check(free_cnt == CNT_W'(DEPTH - 5), "R2 free count", free_cnt, DEPTH - 5);

        // R4: read port after a completion
        complete(2, 1'b0);
        src_idx = 2; #1;
        check(src_ready == 1'b1, "R4 src ready", src_ready, 1);
        check(src_data == 32'hA002, "R4 src data", src_data, 32'hA002);
        src_idx = 0; #1;
        check(src_ready == 1'b0, "R4 not done", src_ready, 0);
        check(ret_valid == '0, "R5 younger waits", ret_valid, 0);

        // R4: completion to an empty slot
        val_tbl[30] = 32'hDEAD;
        complete(30, 1'b0);
        src_idx = 30; #1;
        check(src_ready == 1'b0, "R4 stray ignored", src_ready, 0);

        complete(1, 1'b0);
        complete(3, 1'b0);
        complete(4, 1'b0);
        check(ret_valid == '0, "R5 head not done", ret_valid, 0);

        // R6, R10: burst of three then two
        complete(0, 1'b0);
        check(ret_valid == 3'b111, "R6 width cap", ret_valid, 3'b111);
        check(free_cnt == CNT_W'(DEPTH - 5), "R10 before free", free_cnt, DEPTH - 5);
        step();
        check(ret_valid == 3'b011, "R6 remainder", ret_valid, 3'b011);
        check(free_cnt == CNT_W'(DEPTH - 2), "R10 freed three", free_cnt, DEPTH - 2);
        step();
        check(ret_valid == '0, "R6 idle", ret_valid, 0);
        check(free_cnt == CNT_W'(DEPTH), "R10 all free", free_cnt, DEPTH);

        // R6: run stops at a missing result
        alloc_one(5, 3'd6, 32'hB005, 1'b1);
        alloc_one(6, 3'd7, 32'hB006, 1'b1);
        alloc_one(7, 3'd0, 32'hB007, 1'b1);
        complete(5, 1'b0);
        complete(7, 1'b0);
        check(ret_valid == '0, "R6 gap blocks", ret_valid, 0);
        complete(6, 1'b0);
        check(ret_valid == 3'b011, "R6 gap filled", ret_valid, 3'b011);
        step();

        // R2, R3: fill the window from index 8 with wrap
        for (int i = 0; i < DEPTH; i++) begin
            alloc_one((8 + i) % DEPTH, ARCH_W'(i), 32'hC000 + i, 1'b1);
        end
        check(alloc_ready == 1'b0, "R3 full ready", alloc_ready, 0);
        check(free_cnt == '0, "R3 full count", free_cnt, 0);
        alloc_valid = 1'b1; alloc_arch = 3'd5;
        step();
        alloc_valid = 1'b0;
        check(free_cnt == '0, "R3 extra ignored", free_cnt, 0);
        for (int i = 0; i < DEPTH; i++) complete((8 + i) % DEPTH, 1'b0);
        for (int i = 0; i < 40 && free_cnt != CNT_W'(DEPTH); i++) step();
        check(free_cnt == CNT_W'(DEPTH), "R3 drain", free_cnt, DEPTH);
        check(exp_q.size() == 0, "R3 no phantom entry", exp_q.size(), 0);

        // R8, R9: flagged entry at index 9
        alloc_one(8, 3'd1, 32'hD008, 1'b1);
        alloc_one(9, 3'd2, 32'hD009, 1'b0);
        alloc_one(10, 3'd3, 32'hD00A, 1'b0);
        alloc_one(11, 3'd4, 32'hD00B, 1'b0);
        complete(9, 1'b1);
        complete(10, 1'b0);
        complete(11, 1'b0);
        check(flush == 1'b0, "R8 no early flush", flush, 0);
        complete(8, 1'b0);
        alloc_valid = 1'b1; alloc_arch = 3'd7;
        #1;
        check(flush == 1'b1, "R8 flush", flush, 1);
        check(ret_valid == 3'b001, "R8 no write for flagged", ret_valid, 3'b001);
        step();
        alloc_valid = 1'b0;
        check(free_cnt == CNT_W'(DEPTH), "R9 request dropped", free_cnt, DEPTH);
        check(alloc_idx == IDX_W'(10), "R8 restart index", alloc_idx, 10);
        check(flush == 1'b0, "R8 flush one cycle", flush, 0);
        src_idx = 11; #1;
        check(src_ready == 1'b0, "R8 younger discarded", src_ready, 0);

        alloc_one(10, 3'd5, 32'hE00A, 1'b1);
        complete(10, 1'b0);
        step();
        check(exp_q.size() == 0, "R5 scoreboard empty", exp_q.size(), 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule